// File: doc/BRIEF.md
# Four-Channel Buffered Down-Counting PWM Timer Bank

The block holds four PWM channels behind one small register port. Each channel has a 16-bit working down-counter and a working compare value. Both are loaded from software-written buffer registers, so a new period or duty setting never disturbs the waveform in flight. A load happens in one of two ways. Software can hold a per-channel update bit. Otherwise, when auto-reload is on, the channel reloads by itself each time its count has reached zero.

Every channel counts on a tick taken from a shared free-running prescaler. Channels 0 and 1 share one divider select, and channels 2 and 3 share the other. The non-inverted output is low after a load and goes high on the tick whose decrement lands on the compare value. It then stays high through the zero count. Every per-channel control bit lives in one packed control word. The positions of the fields in that word are fixed.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every readable register (addresses 0 to 13) reads zero and every `pwm_out` bit is low.
- R2: Register map: address 0 is the control word, address 1 the divider selects, 2+2n the count buffer of channel n, 3+2n its compare buffer, and 10+n its working count (read-only). In the control word, channel 0's 4-bit field starts at bit 0 and channel n≥1 starts at bit 4n+4. Within a field, bit 0 is run, bit 1 is update, bit 2 is invert and bit 3 is auto-reload. Bits outside the fields (4 to 7 and 20 up) are not stored and read as zero.
- R3: Writing a count or compare buffer leaves the working count unchanged until a load.
- R4: While a channel's update bit is 1, its working count and compare are loaded from the buffers every cycle, no decrement takes place, and the output is at its inactive level.
- R5: A running channel decrements by one per tick. The tick period is 2, 4, 8 or 16 clocks for select values 0, 1, 2 and 3. The select for channel pair p (channels 2p and 2p+1) is at bits [2p+1:2p] of address 1.
- R6: With auto-reload, count buffer N and compare C<N, the non-inverted output is high for C+1 ticks of every N+1-tick period.
- R7: A compare value equal to the loaded count never drives the output high.
- R8: With auto-reload, the tick after the count is zero reloads the count and compare from the buffers and returns the output low. A compare buffer changed mid-run takes effect at that reload.
- R9: Without auto-reload, the counter stops at zero and stays there, and the output stays high.
- R10: When run is 0, the working count holds its value and the output equals the invert bit.
- R11: When the invert bit is 1, the output is the complement of the non-inverted waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit counters and a 2-bit divider select. This puts channel 3's field at bits 16 to 19, exercises both divider pairs, and reaches the gap at bits 4 to 7. Short count values keep a full reload period at twelve clocks. The high time is therefore measured over windows that are whole multiples of the period, which makes the result independent of the prescaler phase. The divider rates are measured as the clock distance between successive changes of the working count.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int unsigned FIELD_W = 4;

  typedef struct packed {
    logic arl;   // bit 3: auto-reload
    logic inv;   // bit 2: invert output
    logic upd;   // bit 1: load from buffers while set
    logic run;   // bit 0: count enable
  } ch_ctrl_t;

  function automatic int unsigned field_base(input int unsigned ch);
    return (ch == 0) ? 0 : (4 * ch + 4);
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [(1<<SEL_W)-1:0] tick
);
  localparam int unsigned NSEL = 1 << SEL_W;

  logic [NSEL-1:0] pre_q;
  logic [NSEL-1:0] pre_d;

  always_comb pre_d = pre_q + NSEL'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  for (genvar k = 0; k < NSEL; k++) begin : g_tick
    assign tick[k] = &pre_q[k:0];
  end

  // R5: a slower tick always coincides with the fastest one
  a_r5_nested_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    tick[NSEL-1] |-> tick[0]);
  a_r5_fast_tick_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    tick[0] |=> !tick[0]);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  ch_ctrl_t         ctrl,
  input  logic [CNT_W-1:0] cnt_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic [CNT_W-1:0] cnt_work,
  output logic             pwm_pin
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cmp_q, cmp_d, cnt_dec;
  logic             raw_q, raw_d;
  logic             at_zero, step, load, upd_en;

  assign at_zero = (cnt_q == '0);
  assign cnt_dec = cnt_q - CNT_W'(1);
  assign step    = ctrl.run && !ctrl.upd && tick;
  assign load    = ctrl.upd || (step && at_zero && ctrl.arl);
  assign upd_en  = load || (step && !at_zero);

  always_comb begin
    cnt_d = cnt_q;
    cmp_d = cmp_q;
    raw_d = raw_q;
    if (load) begin
      cnt_d = cnt_buf;
      cmp_d = cmp_buf;
      raw_d = 1'b0;
    end else if (step && !at_zero) begin
      cnt_d = cnt_dec;
      if (cnt_dec == cmp_q) raw_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
      raw_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
      raw_q <= raw_d;
    end
  end

  assign cnt_work = cnt_q;
  assign pwm_pin  = (ctrl.run && !ctrl.upd && raw_q) ^ ctrl.inv;

  // R10: stopped channel keeps its count
  a_r10_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !ctrl.upd) |=> $stable(cnt_q));
  // R4: update bit loads buffers
  a_r4_manual_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.upd |=> (cnt_q == $past(cnt_buf)) && (cmp_q == $past(cmp_buf)));
  // R5: decrement by exactly one
  a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_zero) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R6/R7: output only rises where the fresh count meets compare
  a_r7_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> (cnt_q == cmp_q) && $past(step));
  // R8: reload at zero
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_zero && ctrl.arl) |=> (cnt_q == $past(cnt_buf)) && !raw_q);
  // R9: stop at zero without auto-reload
  a_r9_stop_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && !ctrl.arl && !ctrl.upd) |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [DATA_W-1:0]                    wr_data,
  input  logic [NUM_CH-1:0][CNT_W-1:0]         cnt_work,
  output ch_ctrl_t [NUM_CH-1:0]                ctrl,
  output logic [((NUM_CH+1)/2)-1:0][SEL_W-1:0] div_sel,
  output logic [NUM_CH-1:0][CNT_W-1:0]         cnt_buf,
  output logic [NUM_CH-1:0][CNT_W-1:0]         cmp_buf,
  output logic [DATA_W-1:0]                    rd_data
);
  localparam int unsigned NUM_PAIRS  = (NUM_CH + 1) / 2;
  localparam int unsigned DIV_W      = NUM_PAIRS * SEL_W;
  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_DIV   = 1;
  localparam int unsigned ADDR_BUF0  = 2;
  localparam int unsigned ADDR_WORK0 = ADDR_BUF0 + 2 * NUM_CH;

  ch_ctrl_t [NUM_CH-1:0]        ctrl_q, ctrl_d;
  logic [DIV_W-1:0]             div_q, div_d;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf_q, cnt_buf_d, cmp_buf_q, cmp_buf_d;
  logic                         ctrl_we, div_we;
  logic [NUM_CH-1:0]            cnt_we, cmp_we;
  logic                         unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  assign ctrl_we = wr_en && (addr == ADDR_W'(ADDR_CTRL));
  assign div_we  = wr_en && (addr == ADDR_W'(ADDR_DIV));

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      ctrl_d[i]    = wr_data[field_base(i) +: FIELD_W];
      cnt_we[i]    = wr_en && (addr == ADDR_W'(ADDR_BUF0 + 2 * i));
      cmp_we[i]    = wr_en && (addr == ADDR_W'(ADDR_BUF0 + 2 * i + 1));
      cnt_buf_d[i] = wr_data[CNT_W-1:0];
      cmp_buf_d[i] = wr_data[CNT_W-1:0];
    end
    div_d = wr_data[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (div_we) div_q <= div_d;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_buf_q[g] <= '0;
      else if (cnt_we[g]) cnt_buf_q[g] <= cnt_buf_d[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_buf_q[g] <= '0;
      else if (cmp_we[g]) cmp_buf_q[g] <= cmp_buf_d[g];
    end
    // R3: buffer write lands in the buffer only
    a_r3_buf_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we[g] |=> (cnt_buf[g] == $past(wr_data[CNT_W-1:0])));
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_div
    assign div_sel[p] = div_q[p*SEL_W +: SEL_W];
  end

  assign ctrl    = ctrl_q;
  assign cnt_buf = cnt_buf_q;
  assign cmp_buf = cmp_buf_q;

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(ADDR_CTRL)) begin
      for (int i = 0; i < NUM_CH; i++) rd_data[field_base(i) +: FIELD_W] = ctrl_q[i];
    end else if (addr == ADDR_W'(ADDR_DIV)) begin
      rd_data[DIV_W-1:0] = div_q;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(ADDR_BUF0 + 2 * i))     rd_data[CNT_W-1:0] = cnt_buf_q[i];
      if (addr == ADDR_W'(ADDR_BUF0 + 2 * i + 1)) rd_data[CNT_W-1:0] = cmp_buf_q[i];
      if (addr == ADDR_W'(ADDR_WORK0 + i))        rd_data[CNT_W-1:0] = cnt_work[i];
    end
  end

  // R2: a control write stores exactly the addressed field bits
  a_r2_ctrl_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl[NUM_CH-1] == $past(wr_data[field_base(NUM_CH-1) +: FIELD_W])));
endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int unsigned NUM_PAIRS = (NUM_CH + 1) / 2;
  localparam int unsigned NSEL      = 1 << SEL_W;

  logic [1:0]                    rst_sync_q;
  logic                          rst_int_n;
  logic [NSEL-1:0]               tick;
  ch_ctrl_t [NUM_CH-1:0]         ctrl;
  logic [NUM_PAIRS-1:0][SEL_W-1:0] div_sel;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_buf, cmp_buf, cnt_work;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pwm_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .tick(tick)
  );

  pwm_regfile #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .cnt_work(cnt_work), .ctrl(ctrl), .div_sel(div_sel),
    .cnt_buf(cnt_buf), .cmp_buf(cmp_buf), .rd_data(rd_data)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic ch_tick;
    assign ch_tick = tick[div_sel[g/2]];
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_int_n), .tick(ch_tick), .ctrl(ctrl[g]),
      .cnt_buf(cnt_buf[g]), .cmp_buf(cmp_buf[g]),
      .cnt_work(cnt_work[g]), .pwm_pin(pwm_out[g])
    );
    // R11: while stopped the pin sits at the invert level
    a_r11_idle_level: assert property (@(posedge clk) disable iff (!rst_int_n)
      (!ctrl[g].run) |-> (pwm_out[g] == ctrl[g].inv));
  end
endmodule

// File: tb/pwm_timer_bank_tb.sv
module pwm_timer_bank_tb_top;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [3:0]  pwm_out;

  int checks;
  int fails;
  bit finished;

  pwm_timer_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cycles between successive working count changes of channel ch
  task automatic interval(input int ch, output int cyc);
    logic [31:0] prev;
    int i;
    cyc = -1;
    @(negedge clk); addr = 4'(10 + ch); #1 prev = rd_data;
    for (i = 0; i < 100; i++) begin
      @(negedge clk); #1;
      if (rd_data != prev) break;
    end
    prev = rd_data;
    for (int k = 1; k < 100; k++) begin
      @(negedge clk); #1;
      if (rd_data != prev) begin cyc = k; break; end
    end
  endtask

  task automatic high_count(input int ch, input int win, output int hc);
    hc = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) hc++;
    end
  endtask

  task automatic load_ch0(input int cnt, input int cmp);
    wr(4'd2, 32'(cnt));
    wr(4'd3, 32'(cmp));
    wr(4'd0, 32'h2);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 14; a++) begin
      rd(4'(a), v);
      check(v == 0, "R1 reset register", v, 0);
    end
    check(pwm_out == 4'b0, "R1 reset outputs", pwm_out, 0);
  endtask

  task automatic t_buffer_isolation;
    logic [31:0] v;
    wr(4'd2, 32'd77);
    wr(4'd3, 32'd5);
    idle(20);
    rd(4'd10, v);
    check(v == 0, "R3 buffer write isolated", v, 0);
    rd(4'd2, v);
    check(v == 77, "R2 count buffer readback", v, 77);
  endtask

  task automatic t_manual;
    logic [31:0] v;
    wr(4'd0, 32'h3);      // update + run held together
    idle(20);
    rd(4'd10, v);
    check(v == 77, "R4 load and no decrement while update held", v, 77);
    check(pwm_out[0] == 1'b0, "R4 output inactive while update held", pwm_out[0], 0);
    wr(4'd0, 32'h0);
    rd(4'd10, v);
    check(v == 77, "R4 value kept after update cleared", v, 77);
  endtask

  task automatic t_divider;
    int c;
    wr(4'd2, 32'd1000);
    wr(4'd0, 32'h2);
    wr(4'd0, 32'h1);
    for (int s = 0; s < 4; s++) begin
      wr(4'd1, 32'(s));
      idle(20);
      interval(0, c);
      check(c == (2 << s), "R5 tick period pair0", c, 2 << s);
    end
    wr(4'd0, 32'h0);
    wr(4'd1, 32'h0);
  endtask

  task automatic t_waveform;
    int hc;
    load_ch0(5, 2);
    wr(4'd0, 32'h9);
    idle(30);
    high_count(0, 48, hc);
    check(hc == 24, "R6 high time cmp+1 per N+1 ticks", hc, 24);
    wr(4'd3, 32'd0);
    idle(30);
    high_count(0, 48, hc);
    check(hc == 8, "R8 new compare after reload", hc, 8);
    wr(4'd3, 32'd1);
    wr(4'd0, 32'hD);       // invert on
    idle(30);
    high_count(0, 48, hc);
    check(hc == 32, "R11 inverted waveform", hc, 32);
    wr(4'd3, 32'd5);
    wr(4'd0, 32'h9);
    idle(30);
    high_count(0, 48, hc);
    check(hc == 0, "R7 compare equal to count never high", hc, 0);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_stop;
    logic [31:0] v1, v2;
    load_ch0(300, 100);
    wr(4'd0, 32'h9);
    idle(20);
    wr(4'd0, 32'h8);
    rd(4'd10, v1);
    idle(40);
    rd(4'd10, v2);
    check(v1 == v2, "R10 count holds when stopped", v2, v1);
    check(v1 != 300, "R10 channel had been counting", v1, 299);
    check(pwm_out[0] == 1'b0, "R10 stopped output low", pwm_out[0], 0);
    wr(4'd0, 32'h4);
    check(pwm_out[0] == 1'b1, "R10 stopped output follows invert", pwm_out[0], 1);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_no_reload;
    logic [31:0] v;
    load_ch0(3, 1);
    wr(4'd0, 32'h1);
    idle(40);
    rd(4'd10, v);
    check(v == 0, "R9 counter stops at zero", v, 0);
    check(pwm_out[0] == 1'b1, "R9 output stays high at zero", pwm_out[0], 1);
    idle(40);
    rd(4'd10, v);
    check(v == 0, "R9 still zero later", v, 0);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_layout;
    logic [31:0] v, c0;
    int c;
    rd(4'd10, c0);
    wr(4'd4, 32'd7);
    wr(4'd0, 32'h200);     // channel 1 update at bit 9
    wr(4'd0, 32'h0);
    rd(4'd11, v);
    check(v == 7, "R2 channel1 field at bit 8", v, 7);
    rd(4'd10, v);
    check(v == c0, "R2 channel0 untouched", v, c0);
    wr(4'd0, 32'hFFF0_00F0);
    rd(4'd0, v);
    check(v == 0, "R2 gap and upper bits read zero", v, 0);
    idle(20);
    check(pwm_out == 4'b0, "R2 gap bits drive nothing", pwm_out, 0);
    rd(4'd11, v);
    check(v == 7, "R2 gap bits leave channel1 stopped", v, 7);
    wr(4'd8, 32'd500);
    wr(4'd1, 32'hB);       // pair1 select 2, pair0 select 3
    wr(4'd0, 32'h2_0000);  // channel 3 update at bit 17
    wr(4'd0, 32'h1_0000);  // channel 3 run at bit 16
    rd(4'd0, v);
    check(v == 32'h1_0000, "R2 channel3 field readback", v, 32'h10000);
    idle(10);
    interval(3, c);
    check(c == 8, "R5 pair1 select drives channel3", c, 8);
    wr(4'd0, 32'h0);
  endtask

  initial begin
    checks = 0; fails = 0; finished = 0;
    wr_en = 1'b0; addr = '0; wr_data = '0;
    rst_n = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_buffer_isolation();
    t_manual();
    t_divider();
    t_waveform();
    t_stop();
    t_no_reload();
    t_layout();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule